// File: doc/BRIEF.md
# Output port handshake adapter

This block stands between a compute core that produces one result word at a time and an outside consumer that takes it. The core raises a one-cycle write strobe together with a data word. The adapter places that word on the outgoing data bus and reports back a stall flag. A build-time parameter selects one of three handshake styles. In the full style there is an outgoing valid and an incoming acknowledge. The acknowledge-only style has no valid, and the core stalls until the consumer confirms the word. The valid-only style has no acknowledge, and the core never stalls. The valid-only style is also the one to use for the result half of an argument that is both read and written.

The adapter accepts nothing until a start pulse has been seen. The outgoing valid and the new word appear in the same cycle as the accepted write, so no cycle is lost on the way out. When the consumer acknowledges, the valid and the stall drop on the next clock edge. All three ports exist in every style. A port that a style does not use is tied low on the output side and ignored on the input side.

Top module: `out_port_adapter`

## Requirements
- R1: An active-high synchronous reset clears the outgoing valid, the stall flag, the data register (out_data reads 0) and the started state. After reset, writes are ignored again until a new start pulse.
- R2: Before the first start pulse a write has no effect: out_vld and stall stay 0 and out_data keeps its value.
- R3: A start pulse takes effect from the cycle after it. A write in the same cycle as start is ignored.
- R4: MODE selects the handshake style: 0 = full valid/acknowledge, 1 = acknowledge only, 2 = valid only. In modes 0 and 2, an accepted write drives out_vld to 1 and out_data to wr_data in that same cycle.
- R5: In modes 0 and 1, an accepted write with out_ack low raises stall from the next cycle. stall stays high through the cycle in which out_ack is seen high. In mode 0, out_vld stays high over that time.
- R6: In modes 0 and 1, once out_ack is high while a word is pending, stall (and in mode 0, out_vld) is low from the next clock edge, provided no new write is accepted.
- R7: In modes 0 and 1, if out_ack is already high in the cycle of the write, the transfer completes in that cycle and stall never rises.
- R8: In mode 1, out_vld is held at 0 at all times.
- R9: In mode 2, out_vld is a one-cycle pulse for each accepted write, back-to-back writes each give a pulse, stall is always 0, and out_ack has no effect.
- R10: In every mode, whenever no write is accepted, out_data keeps the last accepted word.
- R11: A write presented while stall is high is ignored: the pending word stays on out_data and no extra transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that enables acceptance of writes |
| wr_en | input | 1 | Write strobe from the core |
| wr_data | input | DATA_W | Result word from the core |
| stall | output | 1 | Tells the core to hold off further writes |
| out_data | output | DATA_W | Data bus to the consumer |
| out_vld | output | 1 | Word on out_data is new (modes 0 and 2) |
| out_ack | input | 1 | Consumer has taken the word (modes 0 and 1) |

## Verification
The bench builds three copies side by side with the default 16-bit width: one with MODE 0, one with MODE 1 and one with MODE 2. These copies let every style be driven through the same sequences. Each style is run with the acknowledge arriving in the write cycle, one cycle later and several cycles later. This covers the same-cycle completion and the held stall window. With the valid-only copy the bench can issue back-to-back writes and an acknowledge that does nothing. With the full copy it covers writes refused during a stall and a reset that lands on a pending word.

// File: rtl/adp_pkg.sv
package adp_pkg;

   // Handshake style codes used by the MODE parameter
   localparam int unsigned MODE_FULL = 0;
   localparam int unsigned MODE_ACK  = 1;
   localparam int unsigned MODE_VLD  = 2;

   // Style has an incoming acknowledge that can stall the core
   function automatic bit mode_has_ack(input int unsigned m);
      return m != MODE_VLD;
   endfunction

   // Style drives an outgoing valid
   function automatic bit mode_has_vld(input int unsigned m);
      return m != MODE_ACK;
   endfunction

endpackage

// File: rtl/adp_run_latch.sv
module adp_run_latch (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic run
);

   logic run_q;

   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= run_q | start;
   end

   assign run = run_q;

endmodule

// File: rtl/adp_word_hold.sv
module adp_word_hold #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         take,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst)       data_q <= '0;
      else if (take) data_q <= din;
   end

   // New word bypasses the register in the cycle it is taken
   assign dout = take ? din : data_q;

endmodule

// File: rtl/adp_ack_track.sv
module adp_ack_track
   import adp_pkg::*;
#(
   parameter int unsigned MODE = MODE_FULL
) (
   input  logic clk,
   input  logic rst,
   input  logic take,
   input  logic ack,
   output logic stall,
   output logic vld
);

   logic busy;

   generate
      if (mode_has_ack(MODE)) begin : g_ack
         logic pend_q;
         always_ff @(posedge clk) begin
            if (rst) pend_q <= 1'b0;
            else     pend_q <= (take | pend_q) & ~ack;
         end
         assign stall = pend_q;
         assign busy  = take | pend_q;
      end else begin : g_noack
         logic track_unused;
         assign track_unused = &{1'b0, ack, clk, rst};
         assign stall = 1'b0;
         assign busy  = take;
      end

      if (mode_has_vld(MODE)) begin : g_vld
         assign vld = busy;
      end else begin : g_novld
         assign vld = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/out_port_adapter.sv
module out_port_adapter
   import adp_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned MODE   = MODE_FULL
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              stall,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld,
   input  logic              out_ack
);

   generate
      if (MODE > MODE_VLD) begin : g_bad_mode
         $error("out_port_adapter: MODE must be 0, 1 or 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("out_port_adapter: DATA_W must be at least 1");
      end
   endgenerate

   logic run;
   logic take;
   logic stall_w;

   adp_run_latch u_run (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .run   (run)
   );

   assign take = wr_en & run & ~stall_w;

   adp_word_hold #(.W(DATA_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .take (take),
      .din  (wr_data),
      .dout (out_data)
   );

   adp_ack_track #(.MODE(MODE)) u_track (
      .clk   (clk),
      .rst   (rst),
      .take  (take),
      .ack   (out_ack),
      .stall (stall_w),
      .vld   (out_vld)
   );

   assign stall = stall_w;

endmodule

// File: rtl/adp_chk.sv
module adp_chk
   import adp_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned MODE   = MODE_FULL
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              stall,
   input logic [DATA_W-1:0] out_data,
   input logic              out_vld,
   input logic              out_ack,
   input logic              run
);

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_vld && !stall && out_data == '0));

   // R2
   idle_before_start_chk: assert property (@(posedge clk) disable iff (rst)
      !run |-> (!out_vld && !stall));

   // R10
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!(wr_en && run && !stall) && !$past(rst)) |-> $stable(out_data));

   generate
      if (MODE != MODE_VLD) begin : g_ack_chk
         // R5
         stall_rise_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && run && !stall && !out_ack) |=> stall);
         // R5
         stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (stall && !out_ack) |=> stall);
         // R6
         ack_release_chk: assert property (@(posedge clk) disable iff (rst)
            (stall && out_ack) |=> !stall);
         // R7
         ack_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && run && !stall && out_ack) |=> !stall);
      end
      if (MODE == MODE_FULL) begin : g_full_chk
         // R4
         vld_with_write_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && run && !stall) |-> (out_vld && out_data == wr_data));
         // R5
         vld_during_stall_chk: assert property (@(posedge clk) disable iff (rst)
            stall |-> out_vld);
      end
      if (MODE == MODE_ACK) begin : g_ackonly_chk
         // R8
         no_vld_chk: assert property (@(posedge clk) disable iff (rst)
            !out_vld);
      end
      if (MODE == MODE_VLD) begin : g_vldonly_chk
         // R9
         never_stall_chk: assert property (@(posedge clk) disable iff (rst)
            !stall);
         // R9
         vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            out_vld |-> (wr_en && run));
         // R4
         vld_data_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && run) |-> (out_vld && out_data == wr_data));
      end
   endgenerate

endmodule

bind out_port_adapter adp_chk #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .stall    (stall),
   .out_data (out_data),
   .out_vld  (out_vld),
   .out_ack  (out_ack),
   .run      (run)
);

// File: tb/sim_out_port_adapter.sv
`timescale 1ns/1ps
module sim_out_port_adapter;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst     [3];
   logic         start   [3];
   logic         wr_en   [3];
   logic [W-1:0] wr_data [3];
   logic         out_ack [3];
   logic         stall   [3];
   logic [W-1:0] out_data[3];
   logic         out_vld [3];
   bit           started [3];

   logic [W-1:0] sbq[3][$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   for (genvar g = 0; g < 3; g++) begin : gen_m
      out_port_adapter #(.DATA_W(W), .MODE(g)) u0 (
         .clk      (clk),
         .rst      (rst[g]),
         .start    (start[g]),
         .wr_en    (wr_en[g]),
         .wr_data  (wr_data[g]),
         .stall    (stall[g]),
         .out_data (out_data[g]),
         .out_vld  (out_vld[g]),
         .out_ack  (out_ack[g])
      );
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard whenever a transfer completes at the ports
   initial begin
      forever begin
         @(negedge clk);
         #2;
         for (int m = 0; m < 3; m++) begin
            bit seen;
            if (m == 0)      seen = out_vld[m] && out_ack[m];
            else if (m == 1) seen = out_ack[m] && (stall[m] || (wr_en[m] && started[m]));
            else             seen = out_vld[m];
            if (!rst[m] && seen) begin
               if (sbq[m].size() == 0) begin
                  check(1'b0, "R4 unexpected transfer", 32'(out_data[m]), 32'(m));
               end else begin
                  logic [W-1:0] e;
                  e = sbq[m].pop_front();
                  check(out_data[m] == e, "R4 scoreboard word", 32'(out_data[m]), 32'(e));
               end
            end
         end
      end
   end

   // Driver: one write, acknowledge after lag cycles (0 = in the write cycle)
   task automatic xfer(input int m, input logic [W-1:0] d, input int lag);
      @(negedge clk);
      wr_en[m] = 1'b1; wr_data[m] = d; out_ack[m] = (lag == 0);
      sbq[m].push_back(d);
      #1;
      check(out_vld[m] == (m != 1), (m == 1) ? "R8 no valid" : "R4 valid same cycle",
            32'(out_vld[m]), 32'(m != 1));
      check(out_data[m] == d, "R4 data same cycle", 32'(out_data[m]), 32'(d));
      @(negedge clk);
      wr_en[m] = 1'b0;
      if (m == 2 || lag == 0) begin
         out_ack[m] = 1'b0;
         #1;
         check(stall[m] == 1'b0, (m == 2) ? "R9 never stall" : "R7 no stall", 32'(stall[m]), 0);
         check(out_vld[m] == 1'b0, (m == 2) ? "R9 one-cycle pulse" : "R6 valid drop",
               32'(out_vld[m]), 0);
         check(out_data[m] == d, "R10 data held", 32'(out_data[m]), 32'(d));
         return;
      end
      #1;
      check(stall[m] == 1'b1, "R5 stall rises", 32'(stall[m]), 1);
      check(out_vld[m] == (m == 0), "R5 valid held", 32'(out_vld[m]), 32'(m == 0));
      for (int k = 1; k < lag; k++) begin
         @(negedge clk); #1;
         check(stall[m] == 1'b1, "R5 stall kept", 32'(stall[m]), 1);
      end
      @(negedge clk);
      out_ack[m] = 1'b1;
      #1;
      check(stall[m] == 1'b1, "R5 stall in ack cycle", 32'(stall[m]), 1);
      @(negedge clk);
      out_ack[m] = 1'b0;
      #1;
      check(stall[m] == 1'b0, "R6 stall drop", 32'(stall[m]), 0);
      check(out_vld[m] == 1'b0, "R6 valid drop", 32'(out_vld[m]), 0);
      check(out_data[m] == d, "R10 data held", 32'(out_data[m]), 32'(d));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int m = 0; m < 3; m++) begin
         rst[m] = 1'b1; start[m] = 1'b0; wr_en[m] = 1'b0;
         wr_data[m] = '0; out_ack[m] = 1'b0; started[m] = 1'b0;
      end
      repeat (3) @(negedge clk);
      for (int m = 0; m < 3; m++) rst[m] = 1'b0;
      #1;
      // R1: reset state
      for (int m = 0; m < 3; m++) begin
         check(!out_vld[m] && !stall[m], "R1 reset flags", {out_vld[m], stall[m]}, 0);
         check(out_data[m] == '0, "R1 reset data", 32'(out_data[m]), 0);
      end

      // R2: writes before start do nothing
      for (int m = 0; m < 3; m++) begin
         @(negedge clk);
         wr_en[m] = 1'b1; wr_data[m] = 16'hDEAD;
         #1;
         check(!out_vld[m] && !stall[m], "R2 no valid before start",
               {out_vld[m], stall[m]}, 0);
         check(out_data[m] == '0, "R2 data unchanged", 32'(out_data[m]), 0);
         @(negedge clk);
         wr_en[m] = 1'b0;
         #1;
         check(out_data[m] == '0 && !stall[m], "R2 still idle", 32'(out_data[m]), 0);
      end

      // R3: start with a write in the same cycle; write ignored
      for (int m = 0; m < 3; m++) begin
         @(negedge clk);
         start[m] = 1'b1; wr_en[m] = 1'b1; wr_data[m] = 16'hBEEF;
         #1;
         check(!out_vld[m] && out_data[m] == '0, "R3 start not yet active",
               32'(out_data[m]), 0);
         @(negedge clk);
         start[m] = 1'b0; wr_en[m] = 1'b0; started[m] = 1'b1;
      end

      // Mode 0: full handshake, various ack lags (R4 R5 R6 R7)
      xfer(0, 16'h1111, 0);
      xfer(0, 16'h2222, 1);
      xfer(0, 16'h3333, 3);

      // R11: write while stalled is ignored
      @(negedge clk);
      wr_en[0] = 1'b1; wr_data[0] = 16'hA0A0; out_ack[0] = 1'b0;
      sbq[0].push_back(16'hA0A0);
      @(negedge clk);
      wr_data[0] = 16'hB0B0;
      #1;
      check(out_data[0] == 16'hA0A0, "R11 pending word kept", 32'(out_data[0]), 32'hA0A0);
      check(out_vld[0] == 1'b1, "R11 valid kept", 32'(out_vld[0]), 1);
      @(negedge clk);
      wr_en[0] = 1'b0; out_ack[0] = 1'b1;
      @(negedge clk);
      out_ack[0] = 1'b0;
      #1;
      check(!stall[0] && !out_vld[0], "R11 no extra transfer", {stall[0], out_vld[0]}, 0);
      check(out_data[0] == 16'hA0A0, "R11 refused word absent", 32'(out_data[0]), 32'hA0A0);

      // Mode 1: acknowledge only (R8 R5 R7)
      xfer(1, 16'h4444, 0);
      xfer(1, 16'h4545, 2);

      // Mode 2: valid only (R9)
      xfer(2, 16'h5555, 0);
      @(negedge clk);
      wr_en[2] = 1'b1; wr_data[2] = 16'h6001; sbq[2].push_back(16'h6001);
      #1;
      check(out_vld[2] == 1'b1, "R9 first pulse", 32'(out_vld[2]), 1);
      @(negedge clk);
      wr_data[2] = 16'h6002; sbq[2].push_back(16'h6002);
      #1;
      check(out_vld[2] == 1'b1 && out_data[2] == 16'h6002, "R9 back-to-back pulse",
            32'(out_data[2]), 32'h6002);
      @(negedge clk);
      wr_en[2] = 1'b0;
      #1;
      check(out_vld[2] == 1'b0, "R9 pulse ends", 32'(out_vld[2]), 0);
      check(out_data[2] == 16'h6002, "R10 last word held", 32'(out_data[2]), 32'h6002);
      @(negedge clk);
      out_ack[2] = 1'b1;
      #1;
      check(!stall[2] && !out_vld[2] && out_data[2] == 16'h6002, "R9 ack ignored",
            32'(out_data[2]), 32'h6002);
      @(negedge clk);
      out_ack[2] = 1'b0;

      // R1: reset on a pending word, then started state is gone
      @(negedge clk);
      wr_en[0] = 1'b1; wr_data[0] = 16'h7777;
      @(negedge clk);
      wr_en[0] = 1'b0;
      #1;
      check(stall[0] == 1'b1, "R5 pending before reset", 32'(stall[0]), 1);
      @(negedge clk);
      rst[0] = 1'b1; started[0] = 1'b0;
      @(negedge clk);
      rst[0] = 1'b0;
      #1;
      check(!stall[0] && !out_vld[0], "R1 flags cleared", {stall[0], out_vld[0]}, 0);
      check(out_data[0] == '0, "R1 data cleared", 32'(out_data[0]), 0);
      @(negedge clk);
      wr_en[0] = 1'b1; wr_data[0] = 16'h8888;
      #1;
      check(!out_vld[0] && out_data[0] == '0, "R1 needs new start", 32'(out_data[0]), 0);
      @(negedge clk);
      wr_en[0] = 1'b0;

      repeat (2) @(negedge clk);
      for (int m = 0; m < 3; m++)
         check(sbq[m].size() == 0, "R4 all words delivered", sbq[m].size(), 0);
      finish_run();
   end

endmodule